// File: doc/BRIEF.md
# Five-Function 32-bit Integer ALU

This block is the combinational arithmetic-logic unit of a small RISC execution stage. It receives two operands and a three-bit function code, and it returns a result word together with three flags. The flags report a zero result, the carry out of the adder, and signed overflow. Operand selection and register storage belong to the surrounding datapath. The block holds no state, so every output follows its inputs in the same cycle.

The design has one shared adder. Bit 2 of the function code inverts operand B and also supplies the adder's carry-in. Because of this, subtraction and the signed less-than compare use the same adder as addition. The less-than answer is the sign of the difference corrected by the overflow bit, so it stays correct when the difference overflows. A decode module turns the function code into a small set of strobes. A datapath module uses those strobes to steer the adder, the logic unit and the output selection.

Top module: `alu32_core`

## Requirements
- R1: Function code 3'b000 drives `result` to the bitwise AND of `opA` and `opB`.
- R2: Function code 3'b001 drives `result` to the bitwise OR of `opA` and `opB`.
- R3: Function code 3'b010 drives `result` to `opA + opB` modulo 2^32. `carryOut` is the carry out of bit 31 of that sum.
- R4: Function code 3'b110 drives `result` to `opA - opB`, computed as `opA + ~opB + 1`. `carryOut` is the carry out of bit 31 of that sum, so it is 1 exactly when `opA >= opB` as unsigned numbers.
- R5: Function code 3'b111 drives `result` to 32'd1 when `opA` is less than `opB` as two's-complement numbers, and to 32'd0 otherwise. The answer is also correct when `opA - opB` overflows. Bits 31..1 are always 0.
- R6: For the five defined function codes, `zeroFlag` is 1 exactly when all 32 bits of `result` are 0.
- R7: `overflow` is 1 only under codes 3'b010 and 3'b110. It is set when the two addends of the adder (opA, and opB or ~opB) have the same sign bit and the sign bit of the sum differs from it.
- R8: `carryOut` is 0 under codes 3'b000, 3'b001 and 3'b111.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 drive `result` to 0 and hold `zeroFlag`, `carryOut` and `overflow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| aluCtrl | input | 3 | Function code |
| result | output | 32 | Selected function output |
| zeroFlag | output | 1 | Result is all zeros (defined codes only) |
| carryOut | output | 1 | Carry out of the adder for add and subtract |
| overflow | output | 1 | Signed overflow for add and subtract |

## Verification
The assertions are immediate checks inside the combinational logic. They assume that every input bit is a known 0 or 1 whenever the inputs are stable, which matters most for the function code. The bench meets this assumption by driving every input from time zero. After each change it waits a settling delay before it samples the outputs. Its stimulus covers operands that sit at the signed and unsigned extremes, where the carry, overflow and less-than-correction paths switch. It also covers all eight function codes, and operands that are equal or that cancel to exactly zero.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  typedef enum logic [2:0] {
    FN_AND = 3'b000,
    FN_OR  = 3'b001,
    FN_ADD = 3'b010,
    FN_SUB = 3'b110,
    FN_SLT = 3'b111
  } aluFn_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic invB;      // invert B and force carry-in
    logic useAnd;
    logic useOr;
    logic useSum;
    logic useSlt;
    logic arithFlags; // carry/overflow visible
    logic validFn;    // code is one of the five defined ones
  } aluStrobe_t;

endpackage

// File: rtl/alu32_ctrl.sv
module alu32_ctrl
  import alu32_pkg::*;
(
  input  logic [2:0]  aluCtrl,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    unique case (aluCtrl)
      FN_AND: begin strobe.useAnd = 1'b1; strobe.validFn = 1'b1; end
      FN_OR:  begin strobe.useOr  = 1'b1; strobe.validFn = 1'b1; end
      FN_ADD: begin
        strobe.useSum = 1'b1; strobe.arithFlags = 1'b1; strobe.validFn = 1'b1;
      end
      FN_SUB: begin
        strobe.invB = 1'b1; strobe.useSum = 1'b1;
        strobe.arithFlags = 1'b1; strobe.validFn = 1'b1;
      end
      FN_SLT: begin
        strobe.invB = 1'b1; strobe.useSlt = 1'b1; strobe.validFn = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  // R9: an unused code raises no selection strobe
  always_comb begin
    if (!strobe.validFn)
      a_r9_no_select: assert (!strobe.useAnd && !strobe.useOr && !strobe.useSum
                               && !strobe.useSlt && !strobe.arithFlags);
  end

  // at most one output source is ever selected
  always_comb begin
    a_r6_one_source: assert ($onehot0({strobe.useAnd, strobe.useOr,
                                       strobe.useSum, strobe.useSlt}));
  end

endmodule

// File: rtl/alu32_adder.sv
module alu32_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryMsb,
  output logic             signedOvf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide      = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, carryIn};
    sum       = wide[MSB:0];
    carryMsb  = wide[WIDTH];
    signedOvf = (addA[MSB] == addB[MSB]) && (sum[MSB] != addA[MSB]);
  end

endmodule

// File: rtl/alu32_datapath.sv
module alu32_datapath
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryOut,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] andVal;
  logic [WIDTH-1:0] orVal;
  logic [WIDTH-1:0] sltVal;
  logic             addCarry;
  logic             addOvf;
  logic             lessThan;

  // per-bit logic unit and B inversion
  for (genvar i = 0; i < WIDTH; i++) begin : g_bitslice
    assign bEff[i]   = opB[i] ^ strobe.invB;
    assign andVal[i] = opA[i] & opB[i];
    assign orVal[i]  = opA[i] | opB[i];
  end

  alu32_adder #(.WIDTH(WIDTH)) u_adder (
    .addA     (opA),
    .addB     (bEff),
    .carryIn  (strobe.invB),
    .sum      (sumVal),
    .carryMsb (addCarry),
    .signedOvf(addOvf)
  );

  // sign of difference corrected by overflow
  assign lessThan = sumVal[MSB] ^ addOvf;
  assign sltVal   = {{(WIDTH-1){1'b0}}, lessThan};

  always_comb begin
    result = ({WIDTH{strobe.useAnd}} & andVal)
           | ({WIDTH{strobe.useOr}}  & orVal)
           | ({WIDTH{strobe.useSum}} & sumVal)
           | ({WIDTH{strobe.useSlt}} & sltVal);
    zeroFlag = strobe.validFn && (result == '0);
    carryOut = strobe.arithFlags && addCarry;
    overflow = strobe.arithFlags && addOvf;
  end

  // R5: compare output carries only bit 0
  always_comb begin
    if (strobe.useSlt)
      a_r5_slt_single_bit: assert (result[MSB:1] == '0);
  end

  // R7: overflow needs like-signed addends
  always_comb begin
    if (overflow)
      a_r7_like_signs: assert (opA[MSB] == bEff[MSB] && sumVal[MSB] != opA[MSB]);
  end

endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       aluCtrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             carryOut,
  output logic             overflow
);

  aluStrobe_t strobe;

  alu32_ctrl u_ctrl (
    .aluCtrl(aluCtrl),
    .strobe (strobe)
  );

  alu32_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .zeroFlag(zeroFlag),
    .carryOut(carryOut),
    .overflow(overflow)
  );

  // R7: overflow only for add and subtract codes
  always_comb begin
    if (overflow)
      a_r7_ovf_arith_only: assert (aluCtrl == 3'b010 || aluCtrl == 3'b110);
  end

  // R8: carry only for add and subtract codes
  always_comb begin
    if (carryOut)
      a_r8_carry_arith_only: assert (aluCtrl == 3'b010 || aluCtrl == 3'b110);
  end

  // R9: unused codes are quiet
  always_comb begin
    if (aluCtrl == 3'b011 || aluCtrl == 3'b100 || aluCtrl == 3'b101)
      a_r9_unused_quiet: assert (result == '0 && !zeroFlag && !carryOut && !overflow);
  end

  // R6: a raised zero flag means an all-zero word
  always_comb begin
    if (zeroFlag)
      a_r6_zero_means_zero: assert (result == '0);
  end

endmodule

// File: tb/alu32_core_tb.sv
`timescale 1ns/1ps
module alu32_core_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  aluCtrl = 3'b000;
  logic [31:0] result;
  logic        zeroFlag, carryOut, overflow;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu32_core u_dut (
    .opA(opA), .opB(opB), .aluCtrl(aluCtrl),
    .result(result), .zeroFlag(zeroFlag),
    .carryOut(carryOut), .overflow(overflow)
  );

  // reference model built from the requirements
  task automatic refModel(input logic [2:0] fn, input logic [31:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic z, output logic c, output logic v);
    logic [32:0] w;
    r = '0; c = 1'b0; v = 1'b0;
    case (fn)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: begin
        w = {1'b0, a} + {1'b0, b};
        r = w[31:0]; c = w[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      3'b110: begin
        w = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = w[31:0]; c = w[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    z = (fn inside {3'b000, 3'b001, 3'b010, 3'b110, 3'b111}) && (r == '0);
  endtask

  task automatic checkVec(input string tag, input logic [2:0] fn,
                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er; logic ez, ec, ev;
    @(negedge clk);
    opA = a; opB = b; aluCtrl = fn;
    #1;
    refModel(fn, a, b, er, ez, ec, ev);
    testCount++;
    if (result !== er || zeroFlag !== ez || carryOut !== ec || overflow !== ev) begin
      failCount++;
      $display("FAIL %s fn=%b a=%h b=%h actual r=%h z=%b c=%b v=%b expected r=%h z=%b c=%b v=%b",
               tag, fn, a, b, result, zeroFlag, carryOut, overflow, er, ez, ec, ev);
    end
  endtask

  task automatic testIdle();
    // inputs zero, code AND: zero result, zero flag high
    checkVec("R6", 3'b000, 32'h0, 32'h0);
  endtask

  task automatic testLogic();
    checkVec("R1", 3'b000, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    checkVec("R1", 3'b000, 32'hFFFF_FFFF, 32'h1234_5678);
    checkVec("R2", 3'b001, 32'hF0F0_0000, 32'h0000_0F0F);
    checkVec("R2", 3'b001, 32'h0, 32'h0);
    checkVec("R8", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic testAdd();
    checkVec("R3", 3'b010, 32'd100, 32'd23);
    checkVec("R3", 3'b010, 32'hFFFF_FFFF, 32'h1);
    checkVec("R7", 3'b010, 32'h7FFF_FFFF, 32'h1);
    checkVec("R7", 3'b010, 32'h8000_0000, 32'h8000_0000);
    checkVec("R7", 3'b010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic testSub();
    checkVec("R4", 3'b110, 32'd50, 32'd8);
    checkVec("R4", 3'b110, 32'd8, 32'd50);
    checkVec("R6", 3'b110, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    checkVec("R7", 3'b110, 32'h8000_0000, 32'h1);
    checkVec("R7", 3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    checkVec("R4", 3'b110, 32'h0, 32'h0);
  endtask

  task automatic testSlt();
    checkVec("R5", 3'b111, 32'd3, 32'd9);
    checkVec("R5", 3'b111, 32'd9, 32'd3);
    checkVec("R5", 3'b111, 32'hFFFF_FFFF, 32'h1);
    checkVec("R5", 3'b111, 32'h8000_0000, 32'h1);
    checkVec("R5", 3'b111, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    checkVec("R8", 3'b111, 32'h5, 32'h5);
  endtask

  task automatic testUnused();
    checkVec("R9", 3'b011, 32'hFFFF_FFFF, 32'h1);
    checkVec("R9", 3'b100, 32'h7FFF_FFFF, 32'h1);
    checkVec("R9", 3'b101, 32'h0, 32'h0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 400; i++) begin
      logic [2:0] fn;
      fn = 3'($urandom_range(0, 7));
      checkVec("R3", fn, $urandom(), $urandom());
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testIdle();
    testLogic();
    testAdd();
    testSub();
    testSlt();
    testUnused();
    testRandom();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule